// File: doc/BRIEF.md
# Outstanding-Limited Issue Gate with Address Field Remap

This block sits in front of one master port of a memory-side interconnect. It lets a new read or write request through only while the port has fewer requests in flight than a configured ceiling. The in-flight tally rises when a request is handed onward and falls when the response side returns a one-cycle completion pulse. When the ceiling is reached, the block drops the upstream ready and the downstream valid in the same cycle, without waiting for a clock edge.

On its way through, the request address is rewritten by pure bit rearrangement. The incoming address holds four fields. The byte offset is always the lowest field. The other three fields are the vault, the bank and the row/column, and a 3-bit run-time mode says in which of their six possible orders they appear. The block always emits them in one fixed layout, from MSB to LSB: row/column, bank, vault, offset. Downstream routing can therefore decode the vault from a fixed bit range. A transaction is never split, so the whole request carries one remapped address to a single bank.

Top module: `issue_remap_gate`

## Requirements
- R1: After synchronous active-low reset the in-flight tally is zero: `req_ready` equals `out_ready` and `out_valid` equals `req_valid`.
- R2: While the tally is below `MAX_OT`, `out_valid` = `req_valid` and `req_ready` = `out_ready` in the same cycle, and `out_write` equals `req_write`.
- R3: A request is accepted when `req_valid` and `req_ready` are both high. Once `MAX_OT` requests are in flight, `req_ready` and `out_valid` are both low, and the tally never exceeds `MAX_OT`.
- R4: A `cmpl_pulse` with the tally above zero frees one slot, and `req_ready` is high again in the cycle after the pulse.
- R5: An acceptance and a completion in the same cycle leave the tally unchanged.
- R6: A `cmpl_pulse` while the tally is zero is dropped, even when an acceptance occurs in the same cycle. After such pulses, exactly `MAX_OT` requests can be accepted.
- R7: `out_addr[OFF_W-1:0]` always equals `req_addr[OFF_W-1:0]`.
- R8: `out_addr` is laid out, MSB to LSB, as row/column, bank, vault, offset. The bits above the offset in `req_addr` are read in the order given by `map_mode` (MSB to LSB): 0 = RC,BA,VA; 1 = RC,VA,BA; 2 = BA,RC,VA; 3 = BA,VA,RC; 4 = VA,RC,BA; 5 = VA,BA,RC.
- R9: `map_mode` values 6 and 7 act as mode 0, and mode 0 passes the address through unchanged.
- R10: Remapping is a permutation: `out_addr` has the same number of set bits as `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| map_mode | input | 3 | Field order of the incoming address |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request ready |
| req_addr | input | ADDR_W | Upstream request address |
| req_write | input | 1 | Request is a write (1) or read (0) |
| out_valid | output | 1 | Downstream request valid |
| out_ready | input | 1 | Downstream request ready |
| out_addr | output | ADDR_W | Remapped address in fixed layout |
| out_write | output | 1 | Forwarded write flag |
| cmpl_pulse | input | 1 | One-cycle completion from the response side |

## Verification
The remap and the valid/ready gating are combinational, so their results are due in the same cycle as the stimulus. A change to the in-flight tally is seen one rising edge after the acceptance or completion that causes it. The bench changes inputs on the falling edge and samples 1 ns later, which is before the next rising edge. A gating check therefore sees the tally left by all earlier edges and none of the current cycle's effects. The address sweep runs every mode, including the illegal ones, against a walking-one address. Each output bit is then compared with the position worked out arithmetically from the field widths.

// File: rtl/irg_pkg.sv
// Shared types for the issue gate: the six field orders of the incoming
// address and a helper that folds illegal mode codes onto the default.
package irg_pkg;
    typedef enum logic [2:0] {
        ORD_RC_BA_VA = 3'd0,
        ORD_RC_VA_BA = 3'd1,
        ORD_BA_RC_VA = 3'd2,
        ORD_BA_VA_RC = 3'd3,
        ORD_VA_RC_BA = 3'd4,
        ORD_VA_BA_RC = 3'd5
    } field_order_e;

    // Codes 6 and 7 carry no order; they fall back to the default one.
    function automatic field_order_e legal_order(input logic [2:0] code);
        if (code > 3'd5) return ORD_RC_BA_VA;
        return field_order_e'(code);
    endfunction
endpackage

// File: rtl/irg_slot_counter.sv
// Tracks how many requests of one port are in flight.
// Assumes: take and give are single-cycle events; a give at zero is dropped.
module irg_slot_counter #(
    parameter int MAX_OT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic full
);
    localparam int CW = $clog2(MAX_OT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          give_ok;

    // A completion only counts when something is outstanding.
    assign give_ok = give && (cnt_q != '0);

    // Next tally: up on take, down on a valid give, unchanged on both.
    always_comb begin
        cnt_d = cnt_q;
        if (take && !give_ok)
            cnt_d = cnt_q + CW'(1);
        else if (!take && give_ok)
            cnt_d = cnt_q - CW'(1);
    end

    // Tally register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Ceiling reached flag.
    assign full = (cnt_q == CW'(MAX_OT));
endmodule

// File: rtl/irg_addr_remap.sv
// Reorders the vault, bank and row/column fields of an address into the
// fixed layout {row/column, bank, vault, offset}. Pure wiring per mode.
// Assumes: field widths sum to ADDR_W; offset sits lowest in both layouts.
module irg_addr_remap
    import irg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int VAULT_W = 4,
    parameter int BANK_W  = 1,
    parameter int OFF_W   = 8
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int RC_W = ADDR_W - VAULT_W - BANK_W - OFF_W;
    localparam int PW   = $clog2(ADDR_W);

    // Every field start position that any order can produce.
    localparam logic [PW-1:0] P_LO      = PW'(OFF_W);
    localparam logic [PW-1:0] P_LO_V    = PW'(OFF_W + VAULT_W);
    localparam logic [PW-1:0] P_LO_B    = PW'(OFF_W + BANK_W);
    localparam logic [PW-1:0] P_LO_R    = PW'(OFF_W + RC_W);
    localparam logic [PW-1:0] P_LO_VB   = PW'(OFF_W + VAULT_W + BANK_W);
    localparam logic [PW-1:0] P_LO_VR   = PW'(OFF_W + VAULT_W + RC_W);
    localparam logic [PW-1:0] P_LO_BR   = PW'(OFF_W + BANK_W + RC_W);

    field_order_e  ord;
    logic [PW-1:0] rc_at;
    logic [PW-1:0] ba_at;
    logic [PW-1:0] va_at;

    assign ord = legal_order(mode);

    // Locate each field in the incoming address for the selected order.
    always_comb begin
        unique case (ord)
            ORD_RC_VA_BA: begin ba_at = P_LO;   va_at = P_LO_B;  rc_at = P_LO_VB; end
            ORD_BA_RC_VA: begin va_at = P_LO;   rc_at = P_LO_V;  ba_at = P_LO_VR; end
            ORD_BA_VA_RC: begin rc_at = P_LO;   va_at = P_LO_R;  ba_at = P_LO_VR; end
            ORD_VA_RC_BA: begin ba_at = P_LO;   rc_at = P_LO_B;  va_at = P_LO_BR; end
            ORD_VA_BA_RC: begin rc_at = P_LO;   ba_at = P_LO_R;  va_at = P_LO_BR; end
            default:      begin va_at = P_LO;   ba_at = P_LO_V;  rc_at = P_LO_VB; end
        endcase
    end

    // Assemble the fixed output layout.
    assign addr_out = {addr_in[rc_at +: RC_W],
                       addr_in[ba_at +: BANK_W],
                       addr_in[va_at +: VAULT_W],
                       addr_in[OFF_W-1:0]};
endmodule

// File: rtl/issue_remap_gate.sv
// Per-port issue gate: passes requests only while fewer than MAX_OT are in
// flight, and rewrites the address into the fixed field layout.
// Assumes: cmpl_pulse is one cycle per finished request; gating is
// combinational, so ready and valid drop in the cycle the ceiling is hit.
module issue_remap_gate #(
    parameter int ADDR_W  = 32,
    parameter int VAULT_W = 4,
    parameter int BANK_W  = 1,
    parameter int OFF_W   = 8,
    parameter int MAX_OT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        map_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    input  logic              cmpl_pulse
);
    logic at_cap;
    logic accept;

    // Gating: both directions are closed while the ceiling is reached.
    assign req_ready = out_ready && !at_cap;
    assign out_valid = req_valid && !at_cap;
    assign accept    = req_valid && req_ready;
    assign out_write = req_write;

    irg_slot_counter #(
        .MAX_OT (MAX_OT)
    ) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (accept),
        .give  (cmpl_pulse),
        .full  (at_cap)
    );

    irg_addr_remap #(
        .ADDR_W  (ADDR_W),
        .VAULT_W (VAULT_W),
        .BANK_W  (BANK_W),
        .OFF_W   (OFF_W)
    ) u_remap (
        .mode     (map_mode),
        .addr_in  (req_addr),
        .addr_out (out_addr)
    );
endmodule

// File: rtl/issue_remap_gate_checker.sv
// Property checker for issue_remap_gate, bound to every instance.
// Keeps its own in-flight tally from the port handshakes.
module issue_remap_gate_checker #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 8,
    parameter int MAX_OT  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        map_mode,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              cmpl_pulse
);
    localparam int CW = $clog2(MAX_OT + 2);
    logic [CW-1:0] seen_q;
    logic          acc;
    assign acc = req_valid && req_ready;

    // Shadow tally built from handshakes seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else if (acc && !(cmpl_pulse && seen_q != '0)) seen_q <= seen_q + CW'(1);
        else if (!acc && cmpl_pulse && seen_q != '0)   seen_q <= seen_q - CW'(1);
    end

    a_r2_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> req_valid);
    a_r2_ready_needs_out: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> out_ready);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= CW'(MAX_OT));
    a_r3_closed_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == CW'(MAX_OT)) |-> (!req_ready && !out_valid));
    a_r4_open_below_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q < CW'(MAX_OT) && out_ready) |-> req_ready);
    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr[OFF_W-1:0] == req_addr[OFF_W-1:0]);
    a_r9_default_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (map_mode == 3'd0 || map_mode > 3'd5) |-> out_addr == req_addr);
    a_r10_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_addr) == $countones(req_addr));
endmodule

bind issue_remap_gate issue_remap_gate_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .MAX_OT (MAX_OT)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .map_mode   (map_mode),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .cmpl_pulse (cmpl_pulse)
);

// File: tb/issue_remap_gate_bench.sv
module issue_remap_gate_bench;
    localparam int AW = 32, VW = 4, BW = 1, OW = 8, MOT = 4;
    localparam int RW = AW - VW - BW - OW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    map_mode;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic          out_valid, out_ready, out_write;
    logic [AW-1:0] out_addr;
    logic          cmpl_pulse;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    issue_remap_gate #(.ADDR_W(AW), .VAULT_W(VW), .BANK_W(BW), .OFF_W(OW), .MAX_OT(MOT)) u_issue_remap_gate (
        .clk(clk), .rst_n(rst_n), .map_mode(map_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_write(out_write),
        .cmpl_pulse(cmpl_pulse));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected fixed-layout address, field positions derived from widths.
    function automatic logic [31:0] exp_remap(input int md, input logic [31:0] a);
        int w [3];
        int ord [3];
        logic [31:0] f [3];
        int pos;
        w = '{RW, BW, VW};                   // 0 = row/col, 1 = bank, 2 = vault
        case (md)
            1: ord = '{0, 2, 1};
            2: ord = '{1, 0, 2};
            3: ord = '{1, 2, 0};
            4: ord = '{2, 0, 1};
            5: ord = '{2, 1, 0};
            default: ord = '{0, 1, 2};
        endcase
        pos = OW;
        for (int k = 2; k >= 0; k--) begin
            f[ord[k]] = (a >> pos) & ((32'd1 << w[ord[k]]) - 32'd1);
            pos += w[ord[k]];
        end
        return (f[0] << (OW + VW + BW)) | (f[1] << (OW + VW)) | (f[2] << OW)
             | (a & ((32'd1 << OW) - 32'd1));
    endfunction

    // One cycle: set inputs after the falling edge, sample 1 ns later.
    task automatic drive(input logic v, input logic r, input logic c);
        @(negedge clk);
        req_valid = v; out_ready = r; cmpl_pulse = c;
        #1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int got;
        rst_n = 1'b0; map_mode = 3'd0; req_valid = 1'b0; out_ready = 1'b0;
        req_write = 1'b0; req_addr = '0; cmpl_pulse = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        drive(1'b0, 1'b1, 1'b0);
        chk("R1 ready", req_ready, 1'b1);
        chk("R1 valid", out_valid, 1'b0);

        // R2: pass-through gating and write flag, no acceptance
        req_write = 1'b1;
        drive(1'b1, 1'b0, 1'b0);
        chk("R2 valid", out_valid, 1'b1);
        chk("R2 ready", req_ready, 1'b0);
        chk("R2 write", out_write, 1'b1);
        req_write = 1'b0;
        #0 chk("R2 write low", out_write, 1'b0);

        // R3: fill to the ceiling
        for (int i = 0; i < MOT + 2; i++) begin
            drive(1'b1, 1'b1, 1'b0);
            chk("R3 ready while filling", req_ready, (i < MOT));
            chk("R3 valid while filling", out_valid, (i < MOT));
        end

        // R4: one completion reopens one slot
        drive(1'b0, 1'b1, 1'b1);
        chk("R4 still closed in pulse cycle", req_ready, 1'b0);
        drive(1'b0, 1'b1, 1'b0);
        chk("R4 reopened", req_ready, 1'b1);

        // R5: accept plus completion together keeps tally at MOT-1
        drive(1'b1, 1'b1, 1'b1);
        chk("R5 accepted with completion", req_ready, 1'b1);
        drive(1'b1, 1'b1, 1'b0);
        chk("R5 tally unchanged", req_ready, 1'b1);
        drive(1'b0, 1'b1, 1'b0);
        chk("R5 full after one more", req_ready, 1'b0);

        // R6: drain, then stray completions, then count acceptances
        for (int i = 0; i < MOT + 2; i++) drive(1'b0, 1'b1, 1'b1);
        got = 0;
        for (int i = 0; i < MOT + 3; i++) begin
            drive(1'b1, 1'b1, 1'b0);
            if (req_ready) got++;
        end
        chk("R6 accepts after stray completions", got, MOT);
        // R6: completion at zero with simultaneous accept is dropped
        for (int i = 0; i < MOT; i++) drive(1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
        got = 1;
        for (int i = 0; i < MOT + 2; i++) begin
            drive(1'b1, 1'b1, 1'b0);
            if (req_ready) got++;
        end
        chk("R6 zero-tally completion with accept", got, MOT);
        for (int i = 0; i < MOT; i++) drive(1'b0, 1'b1, 1'b1);

        // R7 R8 R9 R10: walking-one sweep over every mode code
        for (int md = 0; md < 8; md++) begin
            for (int b = 0; b < AW; b++) begin
                @(negedge clk);
                map_mode = 3'(md); req_valid = 1'b0; cmpl_pulse = 1'b0;
                req_addr = 32'd1 << b;
                #1;
                if (b < OW)     chk("R7 offset", out_addr, req_addr);
                else if (md > 5 || md == 0) chk("R9 default order", out_addr, req_addr);
                else            chk("R8 remap", out_addr, exp_remap(md, req_addr));
                chk("R10 one bit set", $countones(out_addr), 1);
            end
        end
        // R8: mixed pattern in every legal mode
        for (int md = 0; md < 6; md++) begin
            @(negedge clk);
            map_mode = 3'(md); req_addr = 32'hA5C3_96E1;
            #1 chk("R8 mixed pattern", out_addr, exp_remap(md, req_addr));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule